// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the digital control half of a self-timed 8-bit successive-approximation converter that is read through a three-wire serial port. The host raises the start input for an autozero interval and then lowers it. The block then approximates the sample by itself, from an internal bit-clock enable derived from the system clock. The result is loaded into an output shift register and presented MSB first, one bit per falling edge of the serial clock. The data output is modelled as a value plus an output-enable, and a disabled enable stands for high impedance.

The analog front end is replaced by a signed behavioural sample. The comparator inside the block keeps a trial bit whenever the trial code does not exceed that sample, so out-of-range inputs clip naturally to the end codes. The block also enforces the host protocol. Serial clock activity during a conversion, or a start pulse during a conversion or readout, raises a status flag. A new conversion is refused until every result bit has been read. If a shutdown aborts a conversion, the block demands a fixed wait followed by a full flush of clock pulses before it will convert again.

Top module: `adc_seq`

## Requirements
- R1: After reset the output-enable is 0 and the status flag is 0. A start input that is already high or low at reset starts nothing until it makes a full low-high-low cycle.
- R2: A conversion starts on the clock after the start input is seen falling, and only if it was sampled high for at least AZ_MIN consecutive clocks. A shorter pulse is ignored.
- R3: During a conversion the output-enable is 1 and the data is 0. The conversion takes WIDTH*CONV_DIV+1 clocks from the first clock that sees the start input low. On the cycle after that the MSB of the result is on the data output.
- R4: The result is straight binary: the sample clipped to the range 0 to 2^WIDTH-1. A negative sample gives 0 and a sample above full scale gives all ones.
- R5: The result shifts out MSB first, advancing one bit per serial clock falling edge. The output-enable drops to 0 on the WIDTH-th falling edge and stays 0 through any further pulses.
- R6: Any serial clock edge during a conversion sets the status flag, and the code is still produced. The flag clears when the next conversion starts.
- R7: A start-input rise during a conversion or during readout sets the status flag. The readout continues with the same bits.
- R8: A start pulse during readout does not start a conversion, either then or after the last bit.
- R9: A low on the active-high wake input disables the output on the next clock and stops any conversion. The status flag is set if a conversion was aborted.
- R10: After a shutdown that aborted a conversion, conversions are refused until RECOVER_WAIT clocks have passed after wake-up and then WIDTH serial clock falling edges have been counted. Edges inside the wait window do not count.
- R11: A shutdown while idle or during readout needs no flush: a conversion can start right after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst_i | input | 1 | Start input; high for autozero, falling edge starts a conversion |
| sclk_i | input | 1 | Serial read clock; data advances on its falling edge |
| awake_i | input | 1 | Active-high wake; low means shutdown |
| sample_i | input | WIDTH+2 | Signed behavioural sample compared by the SAR |
| dout_o | output | 1 | Serial data value |
| dout_en_o | output | 1 | Data output enable; 0 stands for high impedance |
| bad_o | output | 1 | Result corrupted or conversion aborted |

## Verification
The bench builds the block with WIDTH=4, CONV_DIV=3, AZ_MIN=3 and RECOVER_WAIT=20. With a six-bit signed sample, this makes it possible to sweep every sample value from -32 to 31, covering both clipping regions and every in-range code, with exact cycle counts for each conversion. The short wait window lets the bench place a whole flush burst inside the window and show that it is ignored. The bench then shows that a burst one edge short still leaves conversions blocked.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_ARMED   = 3'd0,
        ST_AZ      = 3'd1,
        ST_CONV    = 3'd2,
        ST_READ    = 3'd3,
        ST_OFF     = 3'd4,
        ST_RECOVER = 3'd5
    } seq_state_e;
endpackage

// File: rtl/adc_seq_edge.sv
module adc_seq_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb prev_d = sig_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
    assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_d, div_q;

    assign tick_o = en_i && (div_q == DW'(DIV - 1));

    always_comb begin
        if (!en_i || tick_o) div_d = '0;
        else                 div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/adc_seq_sar_step.sv
module adc_seq_sar_step #(
    parameter int WIDTH = 8,
    parameter int IW    = 4
) (
    input  logic [WIDTH-1:0]        acc_i,
    input  logic [IW-1:0]           idx_i,
    input  logic signed [WIDTH+1:0] sample_i,
    output logic [WIDTH-1:0]        acc_o
);
    logic [WIDTH-1:0]        trial;
    logic signed [WIDTH+1:0] trial_s;

    always_comb begin
        trial = acc_i;
        for (int i = 0; i < WIDTH; i++) begin
            if (idx_i == IW'(i)) trial[i] = 1'b1;
        end
        trial_s = $signed({2'b00, trial});
        acc_o   = (trial_s <= sample_i) ? trial : acc_i;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter int CONV_DIV     = 16,
    parameter int AZ_MIN       = 8,
    parameter int RECOVER_WAIT = 140
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    convst_i,
    input  logic                    sclk_i,
    input  logic                    awake_i,
    input  logic signed [WIDTH+1:0] sample_i,
    output logic                    dout_o,
    output logic                    dout_en_o,
    output logic                    bad_o
);
    localparam int CNT_MAX = (AZ_MIN > RECOVER_WAIT) ? AZ_MIN : RECOVER_WAIT;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int BW      = $clog2(WIDTH + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic [BW-1:0]  bits;
        logic [WIDTH-1:0] sr;
        logic           bad;
        logic           flush;
    } seq_t;

    seq_t r_d, r_q;

    logic cs_rise, cs_fall, sclk_rise, sclk_fall, tick;
    logic [WIDTH-1:0] sar_next;

    adc_seq_edge #(.RST_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(convst_i),
        .rise_o(cs_rise), .fall_o(cs_fall)
    );

    adc_seq_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(sclk_i),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    adc_seq_tick #(.DIV(CONV_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(r_q.st == ST_CONV), .tick_o(tick)
    );

    adc_seq_sar_step #(.WIDTH(WIDTH), .IW(BW)) u_sar (
        .acc_i(r_q.sr), .idx_i(r_q.bits), .sample_i(sample_i), .acc_o(sar_next)
    );

    always_comb begin
        r_d = r_q;
        if (!awake_i) begin
            r_d.st = ST_OFF;
            if (r_q.st == ST_CONV) begin
                r_d.flush = 1'b1;
                r_d.bad   = 1'b1;
            end
        end else begin
            unique case (r_q.st)
                ST_ARMED: begin
                    if (cs_rise) begin
                        r_d.st  = ST_AZ;
                        r_d.cnt = CW'(1);
                    end
                end
                ST_AZ: begin
                    if (cs_fall) begin
                        if (r_q.cnt >= CW'(AZ_MIN)) begin
                            r_d.st   = ST_CONV;
                            r_d.bits = BW'(WIDTH - 1);
                            r_d.sr   = '0;
                            r_d.bad  = 1'b0;
                        end else begin
                            r_d.st = ST_ARMED;
                        end
                    end else if (r_q.cnt < CW'(AZ_MIN)) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (sclk_rise || sclk_fall || cs_rise) r_d.bad = 1'b1;
                    if (tick) begin
                        r_d.sr = sar_next;
                        if (r_q.bits == '0) r_d.st   = ST_READ;
                        else                r_d.bits = r_q.bits - 1'b1;
                    end
                end
                ST_READ: begin
                    if (cs_rise) r_d.bad = 1'b1;
                    if (sclk_fall) begin
                        r_d.sr = r_q.sr << 1;
                        if (r_q.bits == BW'(WIDTH - 1)) begin
                            r_d.st   = ST_ARMED;
                            r_d.bits = '0;
                        end else begin
                            r_d.bits = r_q.bits + 1'b1;
                        end
                    end
                end
                ST_OFF: begin
                    r_d.st   = r_q.flush ? ST_RECOVER : ST_ARMED;
                    r_d.cnt  = '0;
                    r_d.bits = '0;
                    r_d.sr   = '0;
                end
                ST_RECOVER: begin
                    if (r_q.cnt < CW'(RECOVER_WAIT)) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (sclk_fall) begin
                        if (r_q.bits == BW'(WIDTH - 1)) begin
                            r_d.st    = ST_ARMED;
                            r_d.flush = 1'b0;
                            r_d.bits  = '0;
                        end else begin
                            r_d.bits = r_q.bits + 1'b1;
                        end
                    end
                end
                default: r_d.st = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_ARMED;
            r_q.cnt   <= '0;
            r_q.bits  <= '0;
            r_q.sr    <= '0;
            r_q.bad   <= 1'b0;
            r_q.flush <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_en_o = (r_q.st == ST_CONV) || (r_q.st == ST_READ);
    assign dout_o    = (r_q.st == ST_READ) ? r_q.sr[WIDTH-1] : 1'b0;
    assign bad_o     = r_q.bad;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int BW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          awake_i,
    input logic          dout_en_o,
    input logic          bad_o,
    input seq_state_e    st,
    input logic          cs_rise,
    input logic          sclk_edge,
    input logic          sclk_fall,
    input logic [BW-1:0] bits
);
    p_start_from_az_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_CONV) |-> $past(st) == ST_AZ);

    p_last_bit_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && awake_i && sclk_fall && bits == BW'(WIDTH - 1)) |=> !dout_en_o);

    p_sclk_corrupt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CONV && awake_i && sclk_edge) |=> bad_o);

    p_readout_start_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && awake_i && cs_rise) |=> bad_o);

    p_refuse_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && awake_i && !(sclk_fall && bits == BW'(WIDTH - 1))) |=> st == ST_READ);

    p_off_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_i |=> !dout_en_o);

    p_recover_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECOVER) |=> (st == ST_RECOVER || st == ST_ARMED || st == ST_OFF));
endmodule

bind adc_seq adc_seq_chk #(.WIDTH(WIDTH), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .awake_i(awake_i), .dout_en_o(dout_en_o),
    .bad_o(bad_o), .st(r_q.st), .cs_rise(cs_rise),
    .sclk_edge(sclk_rise | sclk_fall), .sclk_fall(sclk_fall), .bits(r_q.bits)
);

// File: tb/sim_adc_seq.sv
module sim_adc_seq;
    localparam int W   = 4;
    localparam int DIV = 3;
    localparam int AZ  = 3;
    localparam int RW  = 20;
    localparam int CT  = W * DIV;

    logic clk = 1'b0, rst_n = 1'b0, convst = 1'b0, sclk = 1'b0, awake = 1'b1;
    logic signed [W+1:0] sample = '0;
    logic dout, dout_en, bad;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    adc_seq #(.WIDTH(W), .CONV_DIV(DIV), .AZ_MIN(AZ), .RECOVER_WAIT(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .convst_i(convst), .sclk_i(sclk), .awake_i(awake),
        .sample_i(sample), .dout_o(dout), .dout_en_o(dout_en), .bad_o(bad)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic az(int h);
        convst = 1'b1; step(h); convst = 1'b0;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin sclk = 1'b1; step(); sclk = 1'b0; step(); end
    endtask

    function automatic int clampv(int s);
        if (s < 0) return 0;
        if (s > (1 << W) - 1) return (1 << W) - 1;
        return s;
    endfunction

    // start a conversion and check the busy phase and the MSB (R3)
    task automatic convert(int s);
        int e;
        e = clampv(s);
        sample = s[W+1:0];
        az(AZ);
        step(CT);
        chk("R3 busy drives low", {30'd0, dout_en, dout}, 2);
        step();
        chk("R3 msb ready", {30'd0, dout_en, dout}, 2 + ((e >> (W - 1)) & 1));
    endtask

    task automatic read_out(int e, string req);
        int got = 0;
        for (int i = 0; i < W; i++) begin
            if (!dout_en) got = -1000;
            got = (got << 1) | int'(dout);
            sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        chk(req, got, e);
        chk("R5 hi-z after last bit", int'(dout_en), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, start input already high
        convst = 1'b1;
        step(3);
        chk("R1 reset enable", int'(dout_en), 0);
        chk("R1 reset flag", int'(bad), 0);
        rst_n = 1'b1;
        step(2);
        convst = 1'b0;
        step(CT + 4);
        chk("R1 no start without rise", int'(dout_en), 0);

        // R2: too-short autozero pulse
        az(AZ - 1);
        step(CT + 2);
        chk("R2 short pulse ignored", int'(dout_en), 0);

        // R2 minimum pulse accepted
        convert(9);
        read_out(9, "R2 minimum pulse result");

        // R4: exhaustive sample sweep
        for (int s = -(1 << (W + 1)); s < (1 << (W + 1)); s++) begin
            convert(s);
            read_out(clampv(s), "R4 code");
            chk("R6 flag clean", int'(bad), 0);
        end

        // R5: extra pulses keep output disabled
        for (int i = 0; i < 3; i++) begin
            pulses(1);
            chk("R5 stays hi-z", int'(dout_en), 0);
        end

        // R6: serial clock during conversion
        sample = 7;
        az(AZ);
        step(2);
        sclk = 1'b1; step(); sclk = 1'b0; step();
        step(CT - 3);
        chk("R6 flag after sclk", int'(bad), 1);
        read_out(7, "R6 code still produced");
        convert(7);
        chk("R6 flag cleared", int'(bad), 0);
        read_out(7, "R6 clean code");

        // R7: start rise during conversion
        sample = 11;
        az(AZ);
        step(2);
        convst = 1'b1; step(); convst = 1'b0;
        step(CT - 2);
        chk("R7 flag conv", int'(bad), 1);
        read_out(11, "R7 readout continues");

        // R7/R8: start pulse during readout
        convert(12);
        az(AZ + 1);
        chk("R7 flag readout", int'(bad), 1);
        chk("R8 still reading", {30'd0, dout_en, dout}, 3);
        read_out(12, "R8 readout unchanged");
        step(CT + 3);
        chk("R8 refused", int'(dout_en), 0);

        // R9/R10: shutdown during conversion
        sample = 10;
        az(AZ);
        step(3);
        awake = 1'b0; step();
        chk("R9 hi-z", int'(dout_en), 0);
        chk("R9 abort flag", int'(bad), 1);
        awake = 1'b1; step();
        pulses(W);
        step(RW);
        az(AZ);
        step(CT + 2);
        chk("R10 early pulses ignored", int'(dout_en), 0);
        pulses(W - 1);
        az(AZ);
        step(CT + 2);
        chk("R10 partial flush", int'(dout_en), 0);
        pulses(1);
        convert(10);
        read_out(10, "R10 after flush");

        // R11: shutdown while idle
        awake = 1'b0; step();
        awake = 1'b1; step();
        convert(3);
        read_out(3, "R11 idle shutdown");

        // R9/R11: shutdown during readout
        convert(14);
        awake = 1'b0; step();
        chk("R9 hi-z readout", int'(dout_en), 0);
        awake = 1'b1; step();
        convert(5);
        read_out(5, "R11 readout shutdown");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule